// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block keeps asynchronous DRAM alive by raising refresh requests on a fixed, programmable period and then running each one as a CAS-before-RAS cycle. A free-running interval timer produces one refresh tick per period. Each tick adds one to a pending count. The memory controller grants the bus through a request/grant handshake. While the bus is not granted, the ticks stack up in a saturating counter. Once the bus is granted, every stacked refresh is issued in turn, one straight after another.

A refresh cycle has three phases. First CAS is driven low for a programmable lead time. Then RAS is driven low with CAS for a programmable low time. Then both strobes are released for a programmable recovery time. A busy indicator stays high for the whole cycle so that the controller can hold off new accesses. A cycle that has started always runs to the end.

Software can stop refreshing with an enable bit. An external (board-level) reset does not stop refresh. While that reset is asserted, the controller's sequencer is itself held in reset, so the block treats the bus as granted and keeps refreshing.

Top module: `refresh_sched`

## Requirements
- R1: While `rstN` is low on a clock edge, the block returns to idle with no pending refreshes and a cleared timer. After that edge, `refReq` and `refActive` are 0, and `casN` and `rasN` are 1.
- R2: With `refreshEn` high, the timer produces one tick every `intervalCfg` clocks; values 0 and 1 both mean every clock. Starting from a cleared timer and no pending refreshes, `refReq` first rises in the cycle after the `intervalCfg`-th clock edge following enable.
- R3: Each refresh cycle drives `casN` low before `rasN`. `rasN` is low only while `casN` is low. Both strobes return high on the same edge.
- R4: The CAS lead lasts `casLeadCfg` clocks, the RAS-low time lasts `rasLowCfg` clocks and the recovery lasts `recoverCfg` clocks. A configured value of 0 counts as 1 clock.
- R5: Ticks that arrive while no cycle can start are stacked in a pending count. The count saturates at 7, so a later grant runs exactly 7 cycles when no further ticks arrive.
- R6: A completed cycle removes one pending refresh. If refreshes remain pending, `refReq` is high in the first cycle after recovery ends, with no idle gap.
- R7: Once a cycle has started, it runs its full CAS, RAS and recovery sequence whatever `refGrant` does.
- R8: With `refreshEn` low, pending refreshes are cleared, the timer is held at zero and `refReq` stays low. A cycle already in progress still completes.
- R9: While `extRst` is high, a pending refresh starts without `refGrant`, and refreshes keep being issued on the programmed period.
- R10: `refReq` is high only when the block is idle, enabled and has a refresh pending. `refActive` is high from the first CAS-lead cycle through the last recovery cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, synchronous |
| refreshEn | input | 1 | Refresh enable from software |
| extRst | input | 1 | External reset indication; acts as an implicit grant |
| intervalCfg | input | TIMER_W | Refresh period in clocks |
| casLeadCfg | input | PHASE_W | CAS lead time in clocks |
| rasLowCfg | input | PHASE_W | RAS low time in clocks |
| recoverCfg | input | PHASE_W | Recovery time in clocks |
| refGrant | input | 1 | Bus grant from the memory controller |
| refReq | output | 1 | Refresh request to the memory controller |
| refActive | output | 1 | A refresh cycle is in progress |
| casN | output | 1 | Column strobe, active low |
| rasN | output | 1 | Row strobe, active low |

## Verification
The hardest state to reach from the ports is a saturated pending count followed by a clean drain. The stimulus withholds the grant across more than seven short refresh periods. It then stretches the period far beyond the drain window before granting, so that exactly seven back-to-back cycles should appear. Disabling in the middle of a cycle, a grant pulse lasting one clock, and refreshing under external reset with the grant held low are reached the same way. A behavioural reference model is compared against every output on every clock.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CAS  = 2'd1,
    PH_RAS  = 2'd2,
    PH_REC  = 2'd3
  } refPhase_e;

  typedef enum logic [1:0] {
    LEN_CAS = 2'd0,
    LEN_RAS = 2'd1,
    LEN_REC = 2'd2
  } lenSel_e;

  typedef struct packed {
    logic    loadPhase;
    lenSel_e lenSel;
    logic    countDown;
    logic    cycleDone;
  } dpStrobes_t;

endpackage

// File: rtl/refresh_dp.sv
module refresh_dp
  import refresh_pkg::*;
#(
  parameter int TIMER_W  = 16,
  parameter int PHASE_W  = 4,
  parameter int PEND_MAX = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refreshEn,
  input  logic [TIMER_W-1:0] intervalCfg,
  input  logic [PHASE_W-1:0] casLeadCfg,
  input  logic [PHASE_W-1:0] rasLowCfg,
  input  logic [PHASE_W-1:0] recoverCfg,
  input  dpStrobes_t         strobes,
  output logic               pendNonZero,
  output logic               phaseZero
);

  localparam int PEND_W = $clog2(PEND_MAX + 1);
  localparam logic [PEND_W-1:0] PEND_TOP = PEND_W'(PEND_MAX);

  // Interval timer
  logic [TIMER_W-1:0] timerQ;
  logic [TIMER_W:0]   timerInc;
  logic               tick;

  assign timerInc = {1'b0, timerQ} + (TIMER_W + 1)'(1);
  assign tick     = refreshEn && (timerInc >= {1'b0, intervalCfg});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerQ <= '0;
    end else if (!refreshEn || tick) begin
      timerQ <= '0;
    end else begin
      timerQ <= timerInc[TIMER_W-1:0];
    end
  end

  // Saturating pending counter: a finished cycle consumes first, then a tick adds
  logic [PEND_W-1:0] pendQ;
  logic [PEND_W-1:0] pendAfterDec;
  logic [PEND_W-1:0] pendNext;
  logic              consume;

  assign consume      = strobes.cycleDone && (pendQ != '0);
  assign pendAfterDec = consume ? pendQ - PEND_W'(1) : pendQ;

  always_comb begin
    if (!refreshEn) begin
      pendNext = '0;
    end else if (tick && (pendAfterDec != PEND_TOP)) begin
      pendNext = pendAfterDec + PEND_W'(1);
    end else begin
      pendNext = pendAfterDec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
    end else begin
      pendQ <= pendNext;
    end
  end

  assign pendNonZero = (pendQ != '0);

  // Shared phase down-counter
  logic [PHASE_W-1:0] phaseQ;
  logic [PHASE_W-1:0] lenRaw;
  logic [PHASE_W-1:0] lenClamped;

  always_comb begin
    unique case (strobes.lenSel)
      LEN_RAS: lenRaw = rasLowCfg;
      LEN_REC: lenRaw = recoverCfg;
      default: lenRaw = casLeadCfg;
    endcase
  end

  assign lenClamped = (lenRaw == '0) ? PHASE_W'(1) : lenRaw;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= '0;
    end else if (strobes.loadPhase) begin
      phaseQ <= lenClamped - PHASE_W'(1);
    end else if (strobes.countDown) begin
      phaseQ <= phaseQ - PHASE_W'(1);
    end
  end

  assign phaseZero = (phaseQ == '0);

  AST_PEND_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ == PEND_TOP && !strobes.cycleDone && refreshEn) |=> (pendQ == PEND_TOP)); // R5

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (!refreshEn) |=> (pendQ == '0 && timerQ == '0)); // R8

  AST_DONE_CONSUMES: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cycleDone && refreshEn && pendQ != '0 && !tick) |=> (pendQ == $past(pendQ) - PEND_W'(1))); // R6

endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refreshEn,
  input  logic       extRst,
  input  logic       refGrant,
  input  logic       pendNonZero,
  input  logic       phaseZero,
  output dpStrobes_t strobes,
  output logic       refReq,
  output logic       refActive,
  output logic       casN,
  output logic       rasN
);

  refPhase_e stateQ, stateNext;
  logic      grantEff;

  // While the board is in reset the controller's sequencer is idle: treat as granted
  assign grantEff = refGrant || extRst;
  assign refReq   = (stateQ == PH_IDLE) && refreshEn && pendNonZero;

  always_comb begin
    stateNext = stateQ;
    strobes   = '{loadPhase: 1'b0, lenSel: LEN_CAS, countDown: 1'b0, cycleDone: 1'b0};
    unique case (stateQ)
      PH_IDLE: begin
        if (refReq && grantEff) begin
          stateNext         = PH_CAS;
          strobes.loadPhase = 1'b1;
          strobes.lenSel    = LEN_CAS;
        end
      end
      PH_CAS: begin
        if (phaseZero) begin
          stateNext         = PH_RAS;
          strobes.loadPhase = 1'b1;
          strobes.lenSel    = LEN_RAS;
        end else begin
          strobes.countDown = 1'b1;
        end
      end
      PH_RAS: begin
        if (phaseZero) begin
          stateNext         = PH_REC;
          strobes.loadPhase = 1'b1;
          strobes.lenSel    = LEN_REC;
        end else begin
          strobes.countDown = 1'b1;
        end
      end
      PH_REC: begin
        if (phaseZero) begin
          stateNext         = PH_IDLE;
          strobes.cycleDone = 1'b1;
        end else begin
          strobes.countDown = 1'b1;
        end
      end
      default: stateNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= PH_IDLE;
    end else begin
      stateQ <= stateNext;
    end
  end

  assign refActive = (stateQ != PH_IDLE);
  assign casN      = !((stateQ == PH_CAS) || (stateQ == PH_RAS));
  assign rasN      = (stateQ != PH_RAS);

  AST_START_ON_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && (refGrant || extRst)) |=> (!casN && rasN && refActive)); // R9

  AST_RAS_AFTER_CAS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> $past(!casN)); // R3

  AST_JOINT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> $rose(casN)); // R3

  AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (refActive && !(stateQ == PH_REC && phaseZero)) |=> refActive); // R7

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int TIMER_W  = 16,
  parameter int PHASE_W  = 4,
  parameter int PEND_MAX = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refreshEn,
  input  logic               extRst,
  input  logic [TIMER_W-1:0] intervalCfg,
  input  logic [PHASE_W-1:0] casLeadCfg,
  input  logic [PHASE_W-1:0] rasLowCfg,
  input  logic [PHASE_W-1:0] recoverCfg,
  input  logic               refGrant,
  output logic               refReq,
  output logic               refActive,
  output logic               casN,
  output logic               rasN
);

  dpStrobes_t strobes;
  logic       pendNonZero;
  logic       phaseZero;

  refresh_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .refreshEn  (refreshEn),
    .extRst     (extRst),
    .refGrant   (refGrant),
    .pendNonZero(pendNonZero),
    .phaseZero  (phaseZero),
    .strobes    (strobes),
    .refReq     (refReq),
    .refActive  (refActive),
    .casN       (casN),
    .rasN       (rasN)
  );

  refresh_dp #(
    .TIMER_W (TIMER_W),
    .PHASE_W (PHASE_W),
    .PEND_MAX(PEND_MAX)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .refreshEn  (refreshEn),
    .intervalCfg(intervalCfg),
    .casLeadCfg (casLeadCfg),
    .rasLowCfg  (rasLowCfg),
    .recoverCfg (recoverCfg),
    .strobes    (strobes),
    .pendNonZero(pendNonZero),
    .phaseZero  (phaseZero)
  );

endmodule

// File: tb/tb_refresh_sched.sv
module tb_refresh_sched;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refreshEn = 1'b0;
  logic        extRst = 1'b0;
  logic [15:0] intervalCfg = 16'd20;
  logic [3:0]  casLeadCfg = 4'd2;
  logic [3:0]  rasLowCfg = 4'd3;
  logic [3:0]  recoverCfg = 4'd2;
  logic        refGrant = 1'b1;
  logic        refReq, refActive, casN, rasN;

  always #10 clk = ~clk;

  refresh_sched dut (
    .clk(clk), .rstN(rstN), .refreshEn(refreshEn), .extRst(extRst),
    .intervalCfg(intervalCfg), .casLeadCfg(casLeadCfg), .rasLowCfg(rasLowCfg),
    .recoverCfg(recoverCfg), .refGrant(refGrant), .refReq(refReq),
    .refActive(refActive), .casN(casN), .rasN(rasN)
  );

  int    checks = 0;
  int    fails = 0;
  int    cycleCount = 0;
  string curTag = "R1";
  bit    compareOn = 1'b0;
  int    casFalls = 0;
  int    reqCycles = 0;
  logic  prevCasN = 1'b1;

  // Behavioural reference: phase 0 idle, 1 CAS lead, 2 RAS low, 3 recovery
  int mTimer = 0, mPend = 0, mPh = 0, mCnt = 0;
  int mTick, mDone, mP;
  bit mReqNow;

  function automatic int lenOf(input logic [3:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mTimer = 0; mPend = 0; mPh = 0; mCnt = 0;
    end else begin
      mReqNow = (mPh == 0) && refreshEn && (mPend > 0);
      mTick   = (refreshEn && (mTimer + 1 >= int'(intervalCfg))) ? 1 : 0;
      mDone   = (mPh == 3 && mCnt == 1) ? 1 : 0;
      case (mPh)
        0: if (mReqNow && (refGrant || extRst)) begin mPh = 1; mCnt = lenOf(casLeadCfg); end
        1: if (mCnt == 1) begin mPh = 2; mCnt = lenOf(rasLowCfg); end else mCnt--;
        2: if (mCnt == 1) begin mPh = 3; mCnt = lenOf(recoverCfg); end else mCnt--;
        default: if (mCnt == 1) mPh = 0; else mCnt--;
      endcase
      if (!refreshEn) begin
        mTimer = 0; mPend = 0;
      end else begin
        mTimer = (mTick != 0) ? 0 : mTimer + 1;
        mP = mPend;
        if (mDone != 0 && mP > 0) mP--;
        if (mTick != 0 && mP < 7) mP++;
        mPend = mP;
      end
    end
  end

  task automatic checkBit(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", tag, what, act, exp, cycleCount);
    end
  endtask

  task automatic checkInt(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rstN && compareOn) begin
      checkBit(curTag, "refReq",    refReq,    (mPh == 0) && refreshEn && (mPend > 0));
      checkBit(curTag, "refActive", refActive, mPh != 0);
      checkBit(curTag, "casN",      casN,      !(mPh == 1 || mPh == 2));
      checkBit(curTag, "rasN",      rasN,      mPh != 2);
    end
    if (prevCasN === 1'b1 && casN === 1'b0) casFalls++;
    if (refReq === 1'b1) reqCycles++;
    prevCasN = casN;
  end

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cycleCount);
      finishRun();
    end
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    waitCycles(3);
    #2;
    // R1: reset state
    checkBit("R1", "refReq",    refReq,    1'b0);
    checkBit("R1", "refActive", refActive, 1'b0);
    checkBit("R1", "casN",      casN,      1'b1);
    checkBit("R1", "rasN",      rasN,      1'b1);

    // R2: first request after intervalCfg edges
    @(negedge clk);
    rstN = 1'b1; refreshEn = 1'b1; compareOn = 1'b1; curTag = "R2";
    waitCycles(19);
    #2 checkBit("R2", "refReq before period", refReq, 1'b0);
    @(negedge clk);
    #2 checkBit("R2", "refReq at period", refReq, 1'b1);

    // R3 and R4: strobe ordering and phase lengths
    curTag = "R3";
    waitCycles(80);
    @(negedge clk);
    curTag = "R4"; casLeadCfg = 4'd0; rasLowCfg = 4'd1; recoverCfg = 4'd0; intervalCfg = 16'd9;
    waitCycles(60);
    @(negedge clk);
    casLeadCfg = 4'd5; rasLowCfg = 4'd4; recoverCfg = 4'd3; intervalCfg = 16'd25;
    waitCycles(80);

    // R5 and R6: stack while not granted, then drain back to back
    @(negedge clk);
    curTag = "R5"; casLeadCfg = 4'd2; rasLowCfg = 4'd3; recoverCfg = 4'd2;
    refGrant = 1'b0; intervalCfg = 16'd5;
    waitCycles(60);
    @(negedge clk);
    curTag = "R6"; intervalCfg = 16'd1000; refGrant = 1'b1; casFalls = 0;
    waitCycles(100);
    checkInt("R5", "cycles run after saturation", casFalls, 7);

    // R7: a one-clock grant still produces a whole cycle
    @(negedge clk);
    curTag = "R7"; refGrant = 1'b0; intervalCfg = 16'd8;
    waitCycles(10);
    @(negedge clk);
    casFalls = 0; refGrant = 1'b1;
    @(negedge clk);
    refGrant = 1'b0;
    waitCycles(30);
    checkInt("R7", "cycles after grant pulse", casFalls, 1);

    // R8: disable in the middle of a cycle
    @(negedge clk);
    curTag = "R8"; refGrant = 1'b1;
    waitCycles(2);
    refreshEn = 1'b0;
    reqCycles = 0;
    waitCycles(60);
    checkInt("R8", "requests while disabled", reqCycles, 0);

    // R9: refresh under external reset without grant
    @(negedge clk);
    curTag = "R9"; refGrant = 1'b0; extRst = 1'b1; refreshEn = 1'b1; intervalCfg = 16'd30;
    casFalls = 0;
    waitCycles(110);
    checkInt("R9", "cycles under external reset", casFalls, 3);

    // R10: irregular grant pattern
    @(negedge clk);
    curTag = "R10"; extRst = 1'b0; intervalCfg = 16'd11;
    for (int i = 0; i < 200; i++) begin
      refGrant = ((i % 7) < 3);
      @(negedge clk);
    end
    compareOn = 1'b0;
    finishRun();
  end

endmodule